// File: doc/BRIEF.md
# Instruction Breakpoint Comparator Unit

This block watches the addresses of instruction fetches and flags a breakpoint when a fetch lands on an address that software has programmed into one of its comparator slots. Each slot holds a 27-bit word address and an action code. The action code says which halfword of the fetched 32-bit word is the breakpoint target: the lower one, the upper one or both. A slot takes part only when its own enable bit and the unit-wide enable are both set. Matches are confined to the low code region, where fetch address bits 31:29 are all zero.

Software programs the unit through a small memory-mapped register port. Reads return data combinationally in the same cycle. Writes take effect at the clock edge. The register at offset 0x000 is the control register, and its bit 0 is the unit enable. Offset 0x004 is a capability word. It reads as all zeros, which means address remapping is not offered. Slot x sits at byte offset 0x008 + 4*x and has this layout: bits 31:30 hold the action code, bits 28:2 the compare address and bit 0 the slot enable. Bits 29 and 1 are reserved.

The unit enable is kept as a two-state machine. In state `UNIT_OFF` no slot can hit. In state `UNIT_ARMED` enabled slots may hit. The transition `ARM` (OFF to ARMED) happens on a control write with bit 0 set. The transition `DISARM` (ARMED to OFF) happens on a control write with bit 0 clear. Any other write leaves the state where it is. The two halfword hit outputs are registered. They reflect the fetch presented in the previous cycle.

Top module: `ibrk_unit`

## Requirements
- R1: After reset, every register reads zero and both hit outputs are low.
- R2: A comparator register keeps bits 31:30, 28:2 and 0 as written. Bits 29 and 1 always read zero, so writing all ones reads back 0xDFFFFFFD.
- R3: The capability word at offset 0x004 reads zero, and writes to it have no effect.
- R4: The control register holds only bit 0, the unit enable. All of its other bits read zero.
- R5: A valid fetch whose address bits 28:2 equal an active slot's compare field, with bits 31:29 zero, raises hits in the cycle after the fetch. Fetch address bits 1:0 are not compared.
- R6: Action code 1 raises only brk_lo, code 2 raises only brk_hi and code 3 raises both. Code 0 never raises a hit.
- R7: A slot hits only when its bit 0 and the unit enable are both set.
- R8: A fetch with any of address bits 31:29 set never raises a hit.
- R9: When several slots match one fetch, each output is the OR of the halfword selections of all matching slots.
- R10: When fetch_valid is low, both hit outputs are low in the next cycle, whatever the address.
- R11: A control write that clears the unit enable suppresses hits for every later fetch. It leaves slot registers intact, so re-enabling restores hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (zero when reg_rd is low) |
| fetch_valid | input | 1 | Fetch address qualifier |
| fetch_addr | input | 32 | Instruction fetch byte address |
| brk_lo | output | 1 | Breakpoint on lower halfword, registered |
| brk_hi | output | 1 | Breakpoint on upper halfword, registered |

## Verification
The hardest case to reach is two or more slots matching the same fetch with different action codes while every other slot stays silent. From the ports this means programming several slots with an identical compare field and then clearing the others. The bench sweeps every slot against every action code with all other slots cleared. It then loads pairs of slots with the same address and every pairing of codes, so that the OR of halfword selections is checked against arithmetic expectations. Separate sweeps cover address bits 31:29 and the sequence of clearing and then restoring the unit enable.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;

    localparam int DATA_W   = 32;
    localparam int COMP_W   = 27;
    localparam int CTRL_OFS = 0;
    localparam int CAP_OFS  = 4;
    localparam int CMP_BASE = 8;

    // Halfword selection carried by each slot
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_LO   = 2'd1,
        ACT_HI   = 2'd2,
        ACT_BOTH = 2'd3
    } act_e;

    typedef struct packed {
        act_e              act;
        logic [COMP_W-1:0] comp;
        logic              en;
    } slot_cfg_t;

    typedef enum logic {
        UNIT_OFF   = 1'b0,
        UNIT_ARMED = 1'b1
    } unit_state_e;

endpackage

// File: rtl/ibrk_regs.sv
module ibrk_regs
    import ibrk_pkg::*;
#(
    parameter int NUM_CMP = 8,
    parameter int ADDR_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output slot_cfg_t [NUM_CMP-1:0]  slot_cfg,
    output logic                     unit_on
);

    localparam int IDX_W   = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;
    localparam int CMP_END = CMP_BASE + 4 * NUM_CMP;

    unit_state_e state_q, state_d;

    logic              hit_ctrl;
    logic              hit_cap;
    logic              hit_slot;
    logic [ADDR_W-1:0] slot_ofs;
    logic [IDX_W-1:0]  slot_idx;

    always_comb begin
        hit_ctrl = (int'(reg_addr) == CTRL_OFS);
        hit_cap  = (int'(reg_addr) == CAP_OFS);
        hit_slot = (int'(reg_addr) >= CMP_BASE) && (int'(reg_addr) < CMP_END)
                   && (reg_addr[1:0] == 2'b00);
        slot_ofs = reg_addr - ADDR_W'(CMP_BASE);
        slot_idx = slot_ofs[IDX_W+1:2];
    end

    // Unit enable state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= UNIT_OFF;
        else        state_q <= state_d;
    end

    // Transitions ARM and DISARM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UNIT_OFF:   if (reg_wr && hit_ctrl && reg_wdata[0])  state_d = UNIT_ARMED;
            UNIT_ARMED: if (reg_wr && hit_ctrl && !reg_wdata[0]) state_d = UNIT_OFF;
            default:    state_d = UNIT_OFF;
        endcase
    end

    assign unit_on = (state_q == UNIT_ARMED);

    // Slot registers, one per comparator
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_cfg[g] <= '0;
            end else if (reg_wr && hit_slot && (int'(slot_idx) == g)) begin
                slot_cfg[g].act  <= act_e'(reg_wdata[31:30]);
                slot_cfg[g].comp <= reg_wdata[28:2];
                slot_cfg[g].en   <= reg_wdata[0];
            end
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (hit_ctrl) begin
                reg_rdata[0] = unit_on;
            end else if (hit_slot) begin
                for (int i = 0; i < NUM_CMP; i++) begin
                    if (int'(slot_idx) == i) begin
                        reg_rdata = {slot_cfg[i].act, 1'b0, slot_cfg[i].comp,
                                     1'b0, slot_cfg[i].en};
                    end
                end
            end
        end
    end

    AST_CAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && hit_cap) |-> (reg_rdata == '0)); // R3

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && hit_ctrl) |-> (reg_rdata[DATA_W-1:1] == '0)); // R4

    AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_ctrl) |=> (unit_on == $past(reg_wdata[0]))); // R11

endmodule

// File: rtl/ibrk_cmp.sv
module ibrk_cmp
    import ibrk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  slot_cfg_t   cfg,
    input  logic        unit_on,
    input  logic [31:2] fetch_word,
    output logic        hit_lo,
    output logic        hit_hi
);

    logic in_code;
    logic addr_eq;
    logic active;
    logic match;

    always_comb begin
        in_code = (fetch_word[31:29] == 3'b000);
        addr_eq = (fetch_word[28:2] == cfg.comp);
        active  = cfg.en && unit_on;
        match   = in_code && addr_eq && active;
    end

    always_comb begin
        hit_lo = 1'b0;
        hit_hi = 1'b0;
        unique case (cfg.act)
            ACT_LO:   hit_lo = match;
            ACT_HI:   hit_hi = match;
            ACT_BOTH: begin hit_lo = match; hit_hi = match; end
            default:  ;
        endcase
    end

    AST_CODE0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.act == ACT_NONE) |-> (!hit_lo && !hit_hi)); // R6

    AST_SLOT_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.en || !unit_on) |-> (!hit_lo && !hit_hi)); // R7

endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit
    import ibrk_pkg::*;
#(
    parameter int NUM_CMP = 8,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fetch_valid,
    input  logic [31:0]       fetch_addr,
    output logic              brk_lo,
    output logic              brk_hi
);

    slot_cfg_t [NUM_CMP-1:0] slot_cfg;
    logic                    unit_on;
    logic [NUM_CMP-1:0]      lo_vec;
    logic [NUM_CMP-1:0]      hi_vec;
    logic                    unused_byte_ofs;

    assign unused_byte_ofs = ^fetch_addr[1:0];

    ibrk_regs #(.NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .slot_cfg (slot_cfg),
        .unit_on  (unit_on)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        ibrk_cmp i_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg       (slot_cfg[g]),
            .unit_on   (unit_on),
            .fetch_word(fetch_addr[31:2]),
            .hit_lo    (lo_vec[g]),
            .hit_hi    (hi_vec[g])
        );
    end

    // Registered, valid-qualified halfword hits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_lo <= 1'b0;
            brk_hi <= 1'b0;
        end else begin
            brk_lo <= fetch_valid && (|lo_vec);
            brk_hi <= fetch_valid && (|hi_vec);
        end
    end

    AST_NO_HIT_OUTSIDE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && (fetch_addr[31:29] != 3'b000)) |=> (!brk_lo && !brk_hi)); // R8

    AST_NO_HIT_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (!brk_lo && !brk_hi)); // R10

    AST_NO_HIT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_on |=> (!brk_lo && !brk_hi)); // R11

endmodule

// File: tb/test_ibrk_unit.sv
module test_ibrk_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NCMP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        brk_lo, brk_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ibrk_unit i_ibrk_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .brk_lo(brk_lo), .brk_hi(brk_hi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    // Present one fetch, return the registered outputs {hi, lo}
    task automatic fetch(input logic v, input logic [31:0] a, output logic [1:0] res);
        @(negedge clk);
        fetch_valid = v; fetch_addr = a;
        @(posedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        res = {brk_hi, brk_lo};
    endtask

    function automatic logic [31:0] slot_word(input int code, input logic [26:0] comp, input bit en);
        return {code[1:0], 1'b0, comp, 1'b0, en};
    endfunction

    function automatic logic [1:0] exp_sel(input int code);
        return {code >= 2, (code == 1) || (code == 3)};
    endfunction

    task automatic clear_slots();
        for (int i = 0; i < NCMP; i++) wr(8'(8 + 4*i), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [1:0]  r;
        logic [26:0] comp;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check("R1 outputs", {30'b0, brk_hi, brk_lo}, 32'h0);
        rd(8'h00, d); check("R1 ctrl", d, 32'h0);
        rd(8'h04, d); check("R1 cap", d, 32'h0);
        for (int i = 0; i < NCMP; i++) begin
            rd(8'(8 + 4*i), d); check("R1 slot", d, 32'h0);
        end

        // R2: slot write mask
        for (int i = 0; i < NCMP; i++) begin
            wr(8'(8 + 4*i), 32'hFFFF_FFFF);
            rd(8'(8 + 4*i), d); check("R2 mask", d, 32'hDFFF_FFFD);
        end
        wr(8'h0C, 32'h2000_0002);
        rd(8'h0C, d); check("R2 reserved only", d, 32'h0);
        clear_slots();

        // R3, R4
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d); check("R3 cap ignores write", d, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); check("R4 ctrl mask", d, 32'h1);

        // R5 R6 R7: every slot against every code
        for (int i = 0; i < NCMP; i++) begin
            for (int c = 0; c < 4; c++) begin
                comp = 27'((i * 32'h0123_4567 + c * 32'h0011_1111) & 32'h07FF_FFFF);
                wr(8'(8 + 4*i), slot_word(c, comp, 1'b1));
                fetch(1'b1, {3'b000, comp, 2'(i)}, r);
                check("R5 R6 match", {30'b0, r}, {30'b0, exp_sel(c)});
                fetch(1'b1, {3'b000, comp ^ 27'(1 << (i + c)), 2'b00}, r);
                check("R5 mismatch", {30'b0, r}, 32'h0);
                wr(8'(8 + 4*i), slot_word(c, comp, 1'b0));
                fetch(1'b1, {3'b000, comp, 2'b00}, r);
                check("R7 slot disabled", {30'b0, r}, 32'h0);
            end
            wr(8'(8 + 4*i), 32'h0);
        end

        // R8: outside code region
        comp = 27'h2AB_CDEF;
        wr(8'h08, slot_word(3, comp, 1'b1));
        for (int t = 1; t < 8; t++) begin
            fetch(1'b1, {3'(t), comp, 2'b00}, r);
            check("R8 outside region", {30'b0, r}, 32'h0);
        end

        // R10: valid low
        fetch(1'b0, {3'b000, comp, 2'b00}, r);
        check("R10 no valid", {30'b0, r}, 32'h0);

        // R9: pairs of slots with the same address
        wr(8'h08, 32'h0);
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                wr(8'h10, slot_word(a, comp, 1'b1));
                wr(8'h24, slot_word(b, comp, 1'b1));
                fetch(1'b1, {3'b000, comp, 2'b11}, r);
                check("R9 OR", {30'b0, r}, {30'b0, exp_sel(a) | exp_sel(b)});
            end
        end

        // R11: disarm, keep registers, re-arm
        wr(8'h10, slot_word(1, comp, 1'b1));
        wr(8'h24, slot_word(2, comp, 1'b1));
        wr(8'h00, 32'h0);
        fetch(1'b1, {3'b000, comp, 2'b00}, r);
        check("R11 disarmed", {30'b0, r}, 32'h0);
        rd(8'h10, d); check("R11 slot kept", d, slot_word(1, comp, 1'b1));
        rd(8'h24, d); check("R11 slot kept", d, slot_word(2, comp, 1'b1));
        wr(8'h00, 32'h1);
        fetch(1'b1, {3'b000, comp, 2'b00}, r);
        check("R11 rearmed", {30'b0, r}, 32'h3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule